// File: doc/BRIEF.md
# Single-Bus Load/Store Microsequencer

This block is a narrow slice of a processor datapath together with the hardwired sequencer that steps it. It runs two instructions. A load copies a byte from a directly addressed memory location into a general register. A store copies a general register into a directly addressed memory location. Every internal move goes over one shared bus. Each step of the sequence names exactly one register that drives the bus and at most one register that captures from it. The enables for those steps are brought out as one-hot vectors so that the surrounding logic can observe them.

The block holds an instruction register, a memory address register, a memory data register and four general registers. A one-cycle `start` pulse is accepted only while the sequencer is idle. The external memory is driven through a read request, a write request, an address and a write-data bus. It answers on read data and a completion handshake. The sequencer stalls on that handshake for as many cycles as the memory needs. It then finishes the instruction, raises `done` for one cycle and returns to idle.

Top module: `lsq_top`

## Requirements
- R1: The instruction word is 11 bits: bit 10 is the opcode (0 = load, 1 = store), bits 9:8 select general register k, and bits 7:0 are the memory address. It is captured when `start` is high while the sequencer is idle.
- R2: The first step of both instructions drives the address field onto the bus (`bus_oe` bit 0) and captures it into the address register (`bus_ie` bit 0). From the next cycle on, `mem_addr` equals the instruction's address.
- R3: A load raises `mem_rd` and holds it until `mem_mfc` is sampled high. `mem_rd` is low in the following cycle. With a memory that answers after D cycles, `mem_rd` stays high for D+1 cycles.
- R4: In the cycle after the read completes, the data register drives the bus (`bus_oe` bit 1) and register k captures it (`bus_ie` bit 2+k). Register k then holds the byte that was read.
- R5: A store first moves register k over the bus into the data register (`bus_oe` bit 2+k, `bus_ie` bit 1). `mem_wr` rises only in the cycle after that move. While `mem_wr` is high, `mem_wdata` equals the value of register k.
- R6: `mem_wr` is held until `mem_mfc` is sampled high and is low in the following cycle.
- R7: `done` is high for exactly one cycle after each instruction completes. The bus enables are then idle, and a new `start` is accepted in the cycle after `done`.
- R8: In every cycle at most one bit of `bus_oe` and at most one bit of `bus_ie` is set, and `mem_rd` and `mem_wr` are never high together.
- R9: A `start` pulse that arrives while an instruction is in progress is ignored: no memory access and no register change results from it.
- R10: Reset clears all general registers and leaves `mem_rd`, `mem_wr`, `done`, `bus_oe` and `bus_ie` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (idle only) |
| instr | input | 11 | Opcode, register index, direct address |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 8 | Memory address (address register) |
| mem_wdata | output | 8 | Write data (data register) |
| mem_rdata | input | 8 | Read data from memory |
| mem_mfc | input | 1 | Memory function complete |
| bus_oe | output | 6 | One-hot bus driver: 0 address field, 1 data reg, 2+k register k |
| bus_ie | output | 6 | One-hot bus capture: 0 address reg, 1 data reg, 2+k register k |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong step order shows up at once on `bus_oe`/`bus_ie`. For example, a data-register drive before the read completes, or a missing register-to-data move before `mem_wr` rises, each appears in the cycle it happens. A wrong captured address appears on `mem_addr` one cycle after the first step. A value latched into the wrong register only becomes visible when a later store writes memory, so each load is followed by a store of the same register to a fresh address. Errors in handshake timing show up as a wrong count of request cycles against the programmed memory delay of 1 to 5 cycles.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int NREG    = 4;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int INSTR_W = 1 + RIDX_W + ADDR_W;
    localparam int NPORT   = 2 + NREG;

    // bus port positions, shared by the driver and capture vectors
    localparam int P_IR   = 0;   // driver: address field of the instruction
    localparam int P_MAR  = 0;   // capture: address register
    localparam int P_MDR  = 1;
    localparam int P_REG0 = 2;

    typedef enum logic {OP_LOAD = 1'b0, OP_STORE = 1'b1} op_e;

    typedef struct packed {
        op_e               op;
        logic [RIDX_W-1:0] ridx;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_RD_WAIT, S_LD_XFER, S_ST_DATA, S_WR_WAIT, S_FIN
    } step_e;

    function automatic logic [NPORT-1:0] port_sel(input int idx);
        return NPORT'(1) << idx;
    endfunction
endpackage

// File: rtl/lsq_ctrl.sv
module lsq_ctrl
    import lsq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  instr_t           instr_in,
    input  logic             mfc,
    output instr_t           ir,
    output logic [NPORT-1:0] oe,
    output logic [NPORT-1:0] ie,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             done
);
    step_e st, st_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE;
            ir <= '0;
        end else begin
            st <= st_nx;
            if (st == S_IDLE && start) ir <= instr_in;
        end
    end

    always_comb begin
        st_nx = st;
        case (st)
            S_IDLE:    if (start) st_nx = S_ADDR;
            S_ADDR:    st_nx = (ir.op == OP_LOAD) ? S_RD_WAIT : S_ST_DATA;
            S_RD_WAIT: if (mfc) st_nx = S_LD_XFER;
            S_LD_XFER: st_nx = S_FIN;
            S_ST_DATA: st_nx = S_WR_WAIT;
            S_WR_WAIT: if (mfc) st_nx = S_FIN;
            S_FIN:     st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    always_comb begin
        oe     = '0;
        ie     = '0;
        mem_rd = (st == S_RD_WAIT);
        mem_wr = (st == S_WR_WAIT);
        done   = (st == S_FIN);
        case (st)
            S_ADDR: begin
                oe = port_sel(P_IR);
                ie = port_sel(P_MAR);
            end
            S_LD_XFER: begin
                oe = port_sel(P_MDR);
                ie = port_sel(P_REG0 + int'(ir.ridx));
            end
            S_ST_DATA: begin
                oe = port_sel(P_REG0 + int'(ir.ridx));
                ie = port_sel(P_MDR);
            end
            default: ;
        endcase
    end

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd && !mfc |=> mem_rd);
    // R3
    rd_release_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd && mfc |=> !mem_rd);
    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr && !mfc |=> mem_wr);
    // R6
    wr_release_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr && mfc |=> !mem_wr);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        st != S_IDLE |=> $stable(ir));
endmodule

// File: rtl/lsq_regfile.sv
module lsq_regfile
    import lsq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NREG-1:0]             we,
    input  logic [DATA_W-1:0]           bus,
    output logic [NREG-1:0][DATA_W-1:0] q
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)        q[i] <= '0;
            else if (we[i]) q[i] <= bus;
        end
    end
endmodule

// File: rtl/lsq_bus.sv
module lsq_bus
    import lsq_pkg::*;
(
    input  logic [NPORT-1:0]            oe,
    input  logic [ADDR_W-1:0]           ir_addr,
    input  logic [DATA_W-1:0]           mdr,
    input  logic [NREG-1:0][DATA_W-1:0] regs,
    output logic [DATA_W-1:0]           bus
);
    always_comb begin
        bus = '0;
        if (oe[P_IR])  bus = bus | DATA_W'(ir_addr);
        if (oe[P_MDR]) bus = bus | mdr;
        for (int i = 0; i < NREG; i++)
            if (oe[P_REG0 + i]) bus = bus | regs[i];
    end
endmodule

// File: rtl/lsq_top.sv
module lsq_top
    import lsq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_mfc,
    output logic [NPORT-1:0]   bus_oe,
    output logic [NPORT-1:0]   bus_ie,
    output logic               done
);
    instr_t                      ir;
    logic [ADDR_W-1:0]           mar;
    logic [DATA_W-1:0]           mdr;
    logic [DATA_W-1:0]           bus;
    logic [NREG-1:0][DATA_W-1:0] regs;

    lsq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .instr_in(instr_t'(instr)),
        .mfc(mem_mfc), .ir(ir), .oe(bus_oe), .ie(bus_ie),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .done(done)
    );

    lsq_bus u_bus (
        .oe(bus_oe), .ir_addr(ir.addr), .mdr(mdr), .regs(regs), .bus(bus)
    );

    lsq_regfile u_rf (
        .clk(clk), .rst(rst), .we(bus_ie[P_REG0 +: NREG]), .bus(bus), .q(regs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mar <= '0;
            mdr <= '0;
        end else begin
            if (bus_ie[P_MAR]) mar <= ADDR_W'(bus);
            if (bus_ie[P_MDR])            mdr <= bus;
            else if (mem_rd && mem_mfc)   mdr <= mem_rdata;
        end
    end

    assign mem_addr  = mar;
    assign mem_wdata = mdr;

    // R8
    one_driver_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(bus_oe) <= 1 && $countones(bus_ie) <= 1);
    // R8
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    // R4
    ld_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd && mem_mfc |=> bus_oe[P_MDR] && $countones(bus_ie[P_REG0 +: NREG]) == 1);
    // R5
    st_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wr) |-> $past(bus_ie[P_MDR]));
    // R2
    addr_latch_chk: assert property (@(posedge clk) disable iff (rst)
        bus_ie[P_MAR] |=> mem_addr == $past(ir.addr));
endmodule

// File: tb/tb_lsq_top.sv
`timescale 1ns/1ps
module tb_lsq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [10:0] instr = '0;
    logic        mem_rd, mem_wr, mem_mfc, done;
    logic [7:0]  mem_addr, mem_wdata, mem_rdata;
    logic [5:0]  bus_oe, bus_ie;

    lsq_top dut (
        .clk(clk), .rst(rst), .start(start), .instr(instr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_mfc(mem_mfc),
        .bus_oe(bus_oe), .bus_ie(bus_ie), .done(done)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // memory model with programmable completion delay
    logic [7:0] mem [256];
    int  dly = 1;
    int  cnt = 0;
    logic mfc_r = 1'b0;
    assign mem_mfc   = mfc_r;
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if ((mem_rd || mem_wr) && !mfc_r) begin
            if (cnt + 1 >= dly) begin
                mfc_r <= 1'b1;
                if (mem_wr) mem[mem_addr] <= mem_wdata;
            end else cnt <= cnt + 1;
        end else begin
            mfc_r <= 1'b0;
            cnt   <= 0;
        end
    end

    // protocol monitor
    int   cur_k = 0;
    logic [7:0] cur_val = '0;
    logic p_rd = 0, p_wr = 0, p_mfc = 0;
    logic [5:0] p_oe = '0, p_ie = '0;
    int   rd_len = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if ($countones(bus_oe) > 1 || $countones(bus_ie) > 1 || (mem_rd && mem_wr))
                chk(0, "R8 bus exclusivity", {bus_oe, bus_ie}, 0);
            if (p_rd && p_mfc) begin
                chk(!mem_rd, "R3 rd release", mem_rd, 0);
                chk(bus_oe == 6'b000010 && bus_ie == (6'd1 << (2 + cur_k)),
                    "R4 mdr to reg", {bus_oe, bus_ie}, {6'b000010, 6'd1 << (2 + cur_k)});
            end
            if (mem_rd) rd_len++;
            else if (p_rd) begin
                chk(rd_len == dly + 1, "R3 rd length", rd_len, dly + 1);
                rd_len = 0;
            end
            if (p_wr && p_mfc) chk(!mem_wr, "R6 wr release", mem_wr, 0);
            if (mem_wr && !p_wr) begin
                chk(p_oe == (6'd1 << (2 + cur_k)) && p_ie == 6'b000010,
                    "R5 reg to mdr before write", {p_oe, p_ie}, {6'd1 << (2 + cur_k), 6'b000010});
                chk(mem_wdata == cur_val, "R5 write data", mem_wdata, cur_val);
            end
        end
        p_rd = mem_rd; p_wr = mem_wr; p_mfc = mem_mfc; p_oe = bus_oe; p_ie = bus_ie;
    end

    logic [7:0] exp_reg [4];

    task automatic run(input bit op, input int k, input int a, input bit poke);
        bit seen = 0;
        cur_k = k;
        cur_val = exp_reg[k];
        @(negedge clk);
        instr = {op, 2'(k), 8'(a)};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R1 R2 first step: address field drives bus into address register
        chk(bus_oe == 6'b000001 && bus_ie == 6'b000001, "R2 first step", {bus_oe, bus_ie}, 12'h041);
        @(negedge clk);
        chk(mem_addr == 8'(a), "R2 address", mem_addr, a);
        for (int i = 0; i < 40 && !seen; i++) begin
            if (poke && i == 1) begin
                instr = {1'b1, 2'(k), 8'd250};
                start = 1'b1;
            end else start = 1'b0;
            if (done) seen = 1;
            else @(negedge clk);
        end
        start = 1'b0;
        chk(seen, "R7 done seen", seen, 1);
        @(negedge clk);
        chk(!done && bus_oe == 0 && bus_ie == 0 && !mem_rd && !mem_wr,
            "R7 done single and idle", {done, bus_oe, bus_ie}, 0);
    endtask

    initial begin
        bit timeout = 0;
        fork
            begin
                repeat (150000) @(posedge clk);
                timeout = 1;
            end
            begin
                for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h3C);
                for (int i = 0; i < 4; i++) exp_reg[i] = 8'h00;
                repeat (3) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                // R10 reset state
                chk(!mem_rd && !mem_wr && !done && bus_oe == 0 && bus_ie == 0,
                    "R10 reset outputs", {mem_rd, mem_wr, done, bus_oe, bus_ie}, 0);
                mem[200] = 8'hAA;
                run(1'b1, 2, 200, 0);
                chk(mem[200] == 8'h00, "R10 register reset value", mem[200], 0);
                // R1 R3 R4 R5 R6 sweep over registers and memory delays
                for (int d = 1; d <= 5; d++) begin
                    for (int k = 0; k < 4; k++) begin
                        automatic logic [7:0] v = 8'((k * 37 + d * 11 + 5) & 255);
                        automatic int dst = 64 + k * 8 + d;
                        dly = d;
                        mem[32] = v;
                        run(1'b0, k, 32, 0);
                        exp_reg[k] = v;
                        run(1'b1, k, dst, 0);
                        chk(mem[dst] == v, "R4 R5 load then store value", mem[dst], v);
                    end
                end
                // R9 start while busy ignored
                dly = 4;
                mem[250] = 8'h5A;
                mem[32] = 8'hC3;
                run(1'b0, 1, 32, 1);
                exp_reg[1] = 8'hC3;
                repeat (3) begin
                    @(negedge clk);
                    chk(!mem_rd && !mem_wr && bus_oe == 0, "R9 no extra activity", {mem_rd, mem_wr, bus_oe}, 0);
                end
                chk(mem[250] == 8'h5A, "R9 ignored store", mem[250], 8'h5A);
                run(1'b1, 1, 251, 0);
                chk(mem[251] == 8'hC3, "R9 load unaffected", mem[251], 8'hC3);
            end
        join_any
        disable fork;
        if (timeout) chk(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule